// File: doc/BRIEF.md
# Non-volatile page update controller

This block updates one page of a non-volatile array whose cells erase to 1 and can only be programmed from 1 to 0. The host first loads a new page image into an internal buffer through a byte-write port. It then pulses `start` with a page address. The controller reads the stored page back one byte per cycle and compares it with the buffer. It picks one of three paths: finish at once, program only, or erase and then program.

For each byte, the controller forms the bits that differ and masks them with the new data. Any set bit in that result is a 0 that has to become 1, and only an erase can do that. After an erase, it reads the page back and expects every byte to be 8'hFF. After programming, it reads the page back and expects the new image. A failed read-back ends the operation with an error.

During the long array operations, the controller only watches the array's busy line. Retries and multi-page loops are left to the caller.

Top module: `nvm_page_updater`

## Requirements
- R1: After reset the block is idle. `busy`, `done`, `error`, `erase_req`, `prog_req` and `arr_rd_en` are all 0.
- R2: If every stored byte already equals the buffered byte, the operation ends with `error`=0. In that case it issues neither `erase_req` nor `prog_req`.
- R3: If some byte differs but no bit has to go from 0 to 1, the page is programmed without an erase. Programming is a bitwise AND of the buffer into the array. Afterwards the array holds the new image.
- R4: If, in any byte, (new XOR stored) AND new is nonzero, then exactly one `erase_req` comes before the program. Erase sets every byte to 8'hFF. Afterwards the array holds the new image.
- R5: If any byte reads other than 8'hFF after the erase, the operation ends with `error`=1 and no `prog_req` is issued.
- R6: If any byte differs from the buffer after programming, the operation ends with `error`=1.
- R7: While an erase or program is in progress, no array read is issued. The controller waits until it has seen `arr_busy` high and then low again.
- R8: A `start` that arrives while `busy`=1 is ignored. Only the page given with the accepted start is touched.
- R9: `done` is a one-cycle pulse at the end of every operation, whether it succeeds or fails. `error` stays set until the next accepted `start` clears it.
- R10: A compare pass reads each byte of the page exactly once. Reads return data one cycle after `arr_rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse for one page update |
| page_addr | input | PA_W | Page to update, captured when the start is accepted |
| buf_we | input | 1 | Write strobe into the page buffer, taken only while idle |
| buf_idx | input | IDX_W | Byte index for the buffer write |
| buf_data | input | 8 | Byte value for the buffer write |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| error | output | 1 | Sticky failure flag from the last operation |
| arr_page | output | PA_W | Page address presented to the array |
| arr_rd_en | output | 1 | Array read strobe |
| arr_idx | output | IDX_W | Byte index for an array read or load |
| arr_rd_data | input | 8 | Read data, valid one cycle after `arr_rd_en` |
| arr_ld_en | output | 1 | Loads `arr_ld_data` into the array's program latch at `arr_idx` |
| arr_ld_data | output | 8 | Byte being loaded for programming |
| erase_req | output | 1 | One-cycle erase command for `arr_page` |
| prog_req | output | 1 | One-cycle program command, issued together with the last byte load |
| arr_busy | input | 1 | Array operation in progress, high from the cycle after a command |

## Verification
The bench targets the three-way decision. A page that differs only by clearable bits must not be erased. A design that tested plain inequality, and not the masked difference, would erase there needlessly. A design that ignored the mask would program over a 0 bit and then fail its verify. The array model can be made to keep one byte after an erase, or one bit set after a program. This shows whether each verify step really ends in an error, and whether a failed erase stops before any program command. Extra starts during an operation, and reads counted while the array is busy, expose a controller that restarts on a new address or polls the data too early.

// File: rtl/nvpu_pkg.sv
// Shared types for the page update controller.
package nvpu_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_COMPARE, ST_ERASE, ST_WAIT_ERASE, ST_VERIFY_ERASE,
        ST_PROGRAM, ST_WAIT_PROG, ST_VERIFY_PROG, ST_DONE, ST_ERROR
    } upd_state_t;
    localparam logic [7:0] ERASED_BYTE = 8'hFF;
endpackage

// File: rtl/nvpu_page_buf.sv
// Holds the new page image written by the host.
// Assumes: writes are gated by the caller and the read port is combinational.
module nvpu_page_buf #(
    parameter int PAGE_BYTES = 8,
    parameter int IDX_W      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data
);
    logic [7:0] bytes_q [PAGE_BYTES];

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_byte
        // One storage byte, written when its index is selected.
        always_ff @(posedge clk) begin
            if (!rst_n)
                bytes_q[g] <= nvpu_pkg::ERASED_BYTE;
            else if (we && wr_idx == IDX_W'(g))
                bytes_q[g] <= wr_data;
        end
    end

    // Combinational lookup for the compare and load paths.
    always_comb begin
        rd_data = nvpu_pkg::ERASED_BYTE;
        for (int i = 0; i < PAGE_BYTES; i++)
            if (rd_idx == IDX_W'(i)) rd_data = bytes_q[i];
    end
endmodule

// File: rtl/nvpu_byte_scan.sv
// Reads a whole page once, one byte per cycle, and compares each byte
// against either the buffered byte or the erased value.
// Assumes: the array returns read data one cycle after rd_en.
module nvpu_byte_scan #(
    parameter int PAGE_BYTES = 8,
    parameter int IDX_W      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             ref_erased,
    input  logic [7:0]       new_byte,
    input  logic [7:0]       rd_data,
    output logic             rd_en,
    output logic [IDX_W-1:0] rd_idx,
    output logic [IDX_W-1:0] cmp_idx,
    output logic             scan_done,
    output logic             any_diff,
    output logic             any_need
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PAGE_BYTES - 1);

    logic             active_q, vld_q;
    logic [IDX_W-1:0] cnt_q, idx_q;
    logic [7:0]       ref_byte;

    assign ref_byte = ref_erased ? nvpu_pkg::ERASED_BYTE : new_byte;
    assign rd_en    = active_q;
    assign rd_idx   = cnt_q;
    assign cmp_idx  = idx_q;

    // Issues reads, aligns returned data, and accumulates the page result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q  <= 1'b0;
            vld_q     <= 1'b0;
            cnt_q     <= '0;
            idx_q     <= '0;
            scan_done <= 1'b0;
            any_diff  <= 1'b0;
            any_need  <= 1'b0;
        end else begin
            scan_done <= 1'b0;
            if (go) begin
                active_q <= 1'b1;
                vld_q    <= 1'b0;
                cnt_q    <= '0;
                any_diff <= 1'b0;
                any_need <= 1'b0;
            end else begin
                vld_q <= active_q;
                idx_q <= cnt_q;
                if (active_q) begin
                    if (cnt_q == LAST_IDX) active_q <= 1'b0;
                    else                   cnt_q    <= cnt_q + 1'b1;
                end
                if (vld_q) begin
                    if (rd_data != ref_byte) any_diff <= 1'b1;
                    if (|((rd_data ^ new_byte) & new_byte)) any_need <= 1'b1;
                    if (idx_q == LAST_IDX) scan_done <= 1'b1;
                end
            end
        end
    end

    // R10: the last returned byte of a pass is followed by the done pulse.
    a_r10_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q && idx_q == LAST_IDX && !go) |=> scan_done);
endmodule

// File: rtl/nvm_page_updater.sv
// Top of the page update controller: decides between skip, program-only
// and erase-then-program, sequences array commands and verifies each step.
// Assumes: the array raises arr_busy in the cycle after erase_req or
// prog_req and keeps it high until the operation is complete.
module nvm_page_updater #(
    parameter int PAGE_BYTES = 8,
    parameter int PA_W       = 2,
    parameter int IDX_W      = (PAGE_BYTES > 1) ? $clog2(PAGE_BYTES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [PA_W-1:0]  page_addr,
    input  logic             buf_we,
    input  logic [IDX_W-1:0] buf_idx,
    input  logic [7:0]       buf_data,
    output logic             busy,
    output logic             done,
    output logic             error,
    output logic [PA_W-1:0]  arr_page,
    output logic             arr_rd_en,
    output logic [IDX_W-1:0] arr_idx,
    input  logic [7:0]       arr_rd_data,
    output logic             arr_ld_en,
    output logic [7:0]       arr_ld_data,
    output logic             erase_req,
    output logic             prog_req,
    input  logic             arr_busy
);
    import nvpu_pkg::*;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PAGE_BYTES - 1);

    upd_state_t       state_q, state_d;
    logic [PA_W-1:0]  page_q;
    logic [IDX_W-1:0] ld_idx_q;
    logic             seen_busy_q, error_q;
    logic             scan_go, scan_done, any_diff, any_need;
    logic             scan_rd_en;
    logic [IDX_W-1:0] scan_rd_idx, scan_cmp_idx, buf_rd_idx;
    logic [7:0]       buf_byte;
    logic             wait_over;

    assign busy        = (state_q != ST_IDLE);
    assign done        = (state_q == ST_DONE) || (state_q == ST_ERROR);
    assign error       = error_q;
    assign arr_page    = page_q;
    assign arr_rd_en   = scan_rd_en;
    assign arr_ld_en   = (state_q == ST_PROGRAM);
    assign arr_ld_data = buf_byte;
    assign arr_idx     = (state_q == ST_PROGRAM) ? ld_idx_q : scan_rd_idx;
    assign erase_req   = (state_q == ST_ERASE);
    assign prog_req    = (state_q == ST_PROGRAM) && (ld_idx_q == LAST_IDX);
    assign buf_rd_idx  = (state_q == ST_PROGRAM) ? ld_idx_q : scan_cmp_idx;
    assign wait_over   = seen_busy_q && !arr_busy;

    nvpu_page_buf #(.PAGE_BYTES(PAGE_BYTES), .IDX_W(IDX_W)) buf_i (
        .clk(clk), .rst_n(rst_n),
        .we(buf_we && !busy), .wr_idx(buf_idx), .wr_data(buf_data),
        .rd_idx(buf_rd_idx), .rd_data(buf_byte)
    );

    nvpu_byte_scan #(.PAGE_BYTES(PAGE_BYTES), .IDX_W(IDX_W)) scan_i (
        .clk(clk), .rst_n(rst_n), .go(scan_go),
        .ref_erased(state_q == ST_VERIFY_ERASE),
        .new_byte(buf_byte), .rd_data(arr_rd_data),
        .rd_en(scan_rd_en), .rd_idx(scan_rd_idx), .cmp_idx(scan_cmp_idx),
        .scan_done(scan_done), .any_diff(any_diff), .any_need(any_need)
    );

    // Next-state decision and scan launch.
    always_comb begin
        state_d = state_q;
        scan_go = 1'b0;
        unique case (state_q)
            ST_IDLE:
                if (start) begin state_d = ST_COMPARE; scan_go = 1'b1; end
            ST_COMPARE:
                if (scan_done) begin
                    if (!any_diff)     state_d = ST_DONE;
                    else if (any_need) state_d = ST_ERASE;
                    else               state_d = ST_PROGRAM;
                end
            ST_ERASE:      state_d = ST_WAIT_ERASE;
            ST_WAIT_ERASE:
                if (wait_over) begin state_d = ST_VERIFY_ERASE; scan_go = 1'b1; end
            ST_VERIFY_ERASE:
                if (scan_done) state_d = any_diff ? ST_ERROR : ST_PROGRAM;
            ST_PROGRAM:
                if (ld_idx_q == LAST_IDX) state_d = ST_WAIT_PROG;
            ST_WAIT_PROG:
                if (wait_over) begin state_d = ST_VERIFY_PROG; scan_go = 1'b1; end
            ST_VERIFY_PROG:
                if (scan_done) state_d = any_diff ? ST_ERROR : ST_DONE;
            ST_DONE:       state_d = ST_IDLE;
            ST_ERROR:      state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // State, page latch, load counter, busy tracking and sticky error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            page_q      <= '0;
            ld_idx_q    <= '0;
            seen_busy_q <= 1'b0;
            error_q     <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                page_q  <= page_addr;
                error_q <= 1'b0;
            end
            if (state_d == ST_ERROR && state_q != ST_ERROR) error_q <= 1'b1;
            if (state_q == ST_PROGRAM) ld_idx_q <= ld_idx_q + 1'b1;
            else                       ld_idx_q <= '0;
            if (state_q == ST_ERASE || prog_req) seen_busy_q <= 1'b0;
            else if (arr_busy)                   seen_busy_q <= 1'b1;
        end
    end

    // R4: a need bit found by the compare leads straight to an erase command.
    a_r4_erase_on_need: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMPARE && scan_done && any_diff && any_need) |=> erase_req);
    // R7: no array read while an erase or program is pending.
    a_r7_no_read_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_ERASE || state_q == ST_WAIT_PROG) |-> !arr_rd_en);
    // R9: done lasts exactly one cycle.
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8: the page address holds for the whole operation.
    a_r8_page_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && state_q != ST_DONE && state_q != ST_ERROR) |=> $stable(page_q));
    // R5, R6: an error only rises out of a verify state.
    a_r5_r6_error_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(error_q) |-> $past(state_q == ST_VERIFY_ERASE || state_q == ST_VERIFY_PROG));
    // R5: a failed erase verify never reaches a program command.
    a_r5_no_prog_after_bad_erase: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_VERIFY_ERASE && scan_done && any_diff) |=> !arr_ld_en);
endmodule

// File: tb/nvm_page_updater_tb_top.sv
module nvm_page_updater_tb_top;
    localparam int N    = 8;
    localparam int PA_W = 2;
    localparam int IW   = 3;
    localparam int NPG  = 4;
    localparam int BUSY_CYC = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [PA_W-1:0] page_addr = '0;
    logic buf_we = 1'b0;
    logic [IW-1:0] buf_idx = '0;
    logic [7:0] buf_data = '0;
    logic busy, done, error;
    logic [PA_W-1:0] arr_page;
    logic arr_rd_en, arr_ld_en, erase_req, prog_req;
    logic [IW-1:0] arr_idx;
    logic [7:0] arr_rd_data, arr_ld_data;
    logic arr_busy;

    always #2.5 clk = ~clk;

    nvm_page_updater #(.PAGE_BYTES(N), .PA_W(PA_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .page_addr(page_addr),
        .buf_we(buf_we), .buf_idx(buf_idx), .buf_data(buf_data),
        .busy(busy), .done(done), .error(error),
        .arr_page(arr_page), .arr_rd_en(arr_rd_en), .arr_idx(arr_idx),
        .arr_rd_data(arr_rd_data), .arr_ld_en(arr_ld_en), .arr_ld_data(arr_ld_data),
        .erase_req(erase_req), .prog_req(prog_req), .arr_busy(arr_busy)
    );

    // Array model: erase to FF, program as bitwise AND, with fault injection.
    logic [7:0] mem [NPG][N];
    logic [7:0] latch [N];
    logic [7:0] rd_q = 8'h00;
    logic busy_q = 1'b0;
    int   cnt = 0;
    bit   pend_erase = 0, pend_prog = 0;
    logic [PA_W-1:0] op_page = '0;
    bit   fault_erase = 0, fault_prog = 0;
    int   n_erase = 0, n_prog = 0, n_rd = 0, n_rd_busy = 0;
    assign arr_rd_data = rd_q;
    assign arr_busy = busy_q;

    always @(posedge clk) begin
        if (arr_rd_en) begin
            rd_q <= mem[arr_page][arr_idx];
            n_rd++;
            if (busy_q) n_rd_busy++;
        end
        if (arr_ld_en) latch[arr_idx] = arr_ld_data;
        if (erase_req) begin
            n_erase++; pend_erase = 1; op_page = arr_page; cnt = BUSY_CYC; busy_q <= 1'b1;
        end else if (prog_req) begin
            n_prog++; pend_prog = 1; op_page = arr_page; cnt = BUSY_CYC; busy_q <= 1'b1;
        end else if (busy_q) begin
            cnt--;
            if (cnt == 0) begin
                for (int i = 0; i < N; i++) begin
                    if (pend_erase) mem[op_page][i] = 8'hFF;
                    if (pend_prog)  mem[op_page][i] = mem[op_page][i] & latch[i];
                end
                if (pend_erase && fault_erase) mem[op_page][0] = 8'h7F;
                if (pend_prog && fault_prog) mem[op_page][1] = mem[op_page][1] | 8'h01;
                pend_erase = 0; pend_prog = 0;
                busy_q <= 1'b0;
            end
        end
    end

    int n_checks = 0, n_fail = 0;
    bit timed_out = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic load_buf(input logic [7:0] img [N]);
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            buf_we = 1'b1; buf_idx = IW'(i); buf_data = img[i];
        end
        @(negedge clk);
        buf_we = 1'b0;
    endtask

    task automatic clear_counts();
        n_erase = 0; n_prog = 0; n_rd = 0; n_rd_busy = 0;
    endtask

    task automatic pulse_start(input logic [PA_W-1:0] pg);
        @(negedge clk);
        start = 1'b1; page_addr = pg;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int t = 0;
        while (!done && t < 2000) begin @(negedge clk); t++; end
        if (!done) begin timed_out = 1; check(0, "watchdog", 0, 1); end
    endtask

    task automatic check_page(input logic [PA_W-1:0] pg, input logic [7:0] img [N], input string req);
        bit ok = 1;
        int bad = 0;
        for (int i = 0; i < N; i++) if (mem[pg][i] != img[i]) begin ok = 0; bad = i; end
        check(ok, req, mem[pg][bad], img[bad]);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(!busy && !done && !error, "R1 status", {busy, done, error}, 0);
        check(!erase_req && !prog_req && !arr_rd_en, "R1 commands", {erase_req, prog_req, arr_rd_en}, 0);
    endtask

    task automatic t_equal();
        logic [7:0] img [N];
        for (int i = 0; i < N; i++) begin img[i] = 8'h30 + 8'(i); mem[1][i] = img[i]; end
        load_buf(img);
        clear_counts();
        pulse_start(2'd1);
        wait_done();
        check(!error, "R2 error", error, 0);
        @(negedge clk);
        check(n_erase == 0 && n_prog == 0, "R2 no commands", n_erase + n_prog, 0);
        check(n_rd == N, "R10 one read per byte", n_rd, N);
        check(!done, "R9 done one cycle", done, 0);
    endtask

    task automatic t_prog_only();
        logic [7:0] img [N];
        for (int i = 0; i < N; i++) begin mem[2][i] = 8'hFF - 8'(i); img[i] = mem[2][i] & 8'hA5; end
        load_buf(img);
        clear_counts();
        pulse_start(2'd2);
        wait_done();
        check(!error, "R3 error", error, 0);
        check(n_erase == 0 && n_prog == 1, "R3 program only", n_erase * 16 + n_prog, 1);
        check_page(2'd2, img, "R3 contents");
        check(n_rd_busy == 0, "R7 no reads while busy", n_rd_busy, 0);
    endtask

    task automatic t_erase_prog();
        logic [7:0] img [N];
        for (int i = 0; i < N; i++) begin mem[0][i] = 8'h0F; img[i] = 8'h0F; end
        img[2] = 8'hF0;
        load_buf(img);
        clear_counts();
        pulse_start(2'd0);
        wait_done();
        check(!error, "R4 error", error, 0);
        check(n_erase == 1 && n_prog == 1, "R4 erase then program", n_erase * 16 + n_prog, 17);
        check_page(2'd0, img, "R4 contents");
        check(n_rd_busy == 0, "R7 no reads while busy", n_rd_busy, 0);
        check(n_rd == 3 * N, "R10 reads over three passes", n_rd, 3 * N);
    endtask

    task automatic t_erase_fail();
        logic [7:0] img [N];
        for (int i = 0; i < N; i++) begin mem[3][i] = 8'h00; img[i] = 8'h55; end
        load_buf(img);
        clear_counts();
        fault_erase = 1;
        pulse_start(2'd3);
        wait_done();
        fault_erase = 0;
        check(error, "R5 error", error, 1);
        check(n_prog == 0, "R5 no program", n_prog, 0);
        repeat (5) @(negedge clk);
        check(error, "R9 error sticky", error, 1);
    endtask

    task automatic t_prog_fail();
        logic [7:0] img [N];
        for (int i = 0; i < N; i++) begin mem[1][i] = 8'hFF; img[i] = 8'hFE; end
        load_buf(img);
        clear_counts();
        fault_prog = 1;
        pulse_start(2'd1);
        wait_done();
        fault_prog = 0;
        check(error, "R6 error", error, 1);
        check(n_prog == 1 && n_erase == 0, "R6 one program", n_erase * 16 + n_prog, 1);
        // retry on a matching page: the start clears the flag
        for (int i = 0; i < N; i++) mem[1][i] = 8'hFE;
        pulse_start(2'd1);
        check(!error, "R9 error cleared by start", error, 0);
        wait_done();
        check(!error, "R9 clean retry", error, 0);
    endtask

    task automatic t_busy_start();
        logic [7:0] img [N];
        logic [7:0] ff [N];
        for (int i = 0; i < N; i++) begin
            mem[2][i] = 8'h00; mem[3][i] = 8'hFF; img[i] = 8'hC3 ^ 8'(i); ff[i] = 8'hFF;
        end
        load_buf(img);
        clear_counts();
        pulse_start(2'd2);
        repeat (3) @(negedge clk);
        pulse_start(2'd3);
        repeat (25) @(negedge clk);
        pulse_start(2'd3);
        wait_done();
        check(!error, "R8 error", error, 0);
        check(n_erase == 1 && n_prog == 1, "R8 single operation", n_erase * 16 + n_prog, 17);
        check_page(2'd2, img, "R8 accepted page");
        check_page(2'd3, ff, "R8 other page untouched");
        @(negedge clk);
        check(!busy, "R8 idle after done", busy, 0);
    endtask

    initial begin
        for (int p = 0; p < NPG; p++)
            for (int i = 0; i < N; i++) mem[p][i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_equal();
        t_prog_only();
        t_erase_prog();
        t_erase_fail();
        t_prog_fail();
        t_busy_start();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #400000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule